// File: doc/BRIEF.md
# Clause Implication Array

This block holds the clauses of one partition of a CNF problem and the assignment state of that partition's variables. A decision controller writes one variable assignment at a time. Every clause slot then evaluates the current assignment in parallel, and every unit clause forces its last open literal. These forced assignments ripple through the array one wave per clock until no clause yields a new implication. Each variable keeps its value, the decision level it belongs to, the partition number in which it was set, and whether it was decided or implied.

The array reports three conditions: that propagation is still running, that every loaded clause is satisfied, and that some clause has all of its literals false. For a conflict it also gives the variable mask of the offending clause, so that the controller can build a learned clause. Learned clauses are written through the same load port into spare slots above the original clauses. From then on they take part in evaluation like any other clause. A query port tells the controller whether a candidate decision variable can be skipped. A backtrack input clears every assignment above a given level, and a clear input drops all assignments when a new partition is brought in.

Top module: `bin_implication_array`

## Requirements
- R1: Clause slot `s` is written by `wr_en_i` with `wr_slot_i`, `wr_row_i` and `wr_valid_i`. In the row, bits [2v+1:2v] encode variable v as 2'b00 absent, 2'b01 positive literal, or 2'b10 negative literal. A slot whose valid bit is 0 takes no part in any output.
- R2: When `asg_en_i` is high at a rising edge, variable `asg_var_i` becomes assigned. From that edge it reads back value `asg_val_i`, level `asg_lvl_i`, partition `cur_bin_i`, and implied flag 0.
- R3: A valid clause that has no true literal and exactly one unassigned variable is unit. At the next edge that variable is assigned the value that makes its literal true, with its implied flag set. All unit clauses act in the same cycle, so a chain of N implications takes N cycles.
- R4: An implied variable takes as its level the level of the most recent assignment or backtrack (`asg_lvl_i` or `bt_lvl_i`), and takes `cur_bin_i` as its partition.
- R5: `busy_o` is high in the cycle after an assignment, backtrack or clause write. It stays high while the previous edge applied at least one implication, and it falls in the first cycle after an edge that applied none.
- R6: `conflict_o` is high when some valid clause has every literal assigned false. `conf_vars_o` then holds the variable mask of the lowest-indexed such slot, and is zero otherwise. No implication is applied while `conflict_o` is high.
- R7: `sat_o` is high when every valid clause has at least one true literal and no conflict is present. It is high with no valid clause loaded.
- R8: `skip_o` is high when variable `qry_var_i` appears in no valid clause that is still unsatisfied.
- R9: `bt_en_i` unassigns, at that edge, every variable whose level exceeds `bt_lvl_i`. Propagation then resumes.
- R10: `clr_i` unassigns every variable at that edge and leaves the clause slots unchanged.
- R11: Slots `NUM_CLAUSES` and above hold learned clauses. They are loaded, evaluated, take part in conflicts and imply exactly as original slots do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Clause slot write strobe |
| wr_slot_i | input | SLOT_W | Slot index to write |
| wr_row_i | input | 2*NUM_VARS | Literal row, two bits per variable |
| wr_valid_i | input | 1 | Valid bit for the written slot |
| clr_i | input | 1 | Unassign all variables |
| bt_en_i | input | 1 | Backtrack strobe |
| bt_lvl_i | input | LVL_W | Highest level kept by a backtrack |
| asg_en_i | input | 1 | Assignment strobe |
| asg_var_i | input | VAR_W | Variable to assign |
| asg_val_i | input | 1 | Value to assign |
| asg_lvl_i | input | LVL_W | Decision level of the assignment |
| cur_bin_i | input | BIN_W | Number of the partition currently loaded |
| qry_var_i | input | VAR_W | Variable asked about by skip_o |
| var_asg_o | output | NUM_VARS | Assigned flag per variable |
| var_val_o | output | NUM_VARS | Value per variable |
| var_imp_o | output | NUM_VARS | Implied flag per variable |
| var_lvl_o | output | NUM_VARS*LVL_W | Level per variable, variable v at [v*LVL_W +: LVL_W] |
| var_bin_o | output | NUM_VARS*BIN_W | Partition per variable, variable v at [v*BIN_W +: BIN_W] |
| busy_o | output | 1 | Propagation in progress |
| sat_o | output | 1 | Every valid clause satisfied |
| conflict_o | output | 1 | Some valid clause fully false |
| conf_vars_o | output | NUM_VARS | Variables of the conflicting clause |
| skip_o | output | 1 | Queried variable needs no decision |

## Verification
The checker watches several properties on every cycle. It confirms that `sat_o` and `conflict_o` are never high together, that the conflict mask is empty without a conflict, and that `busy_o` rises after each assignment. It confirms that a clear or backtrack removes the assignments it targets, that a variable which becomes assigned without an assignment strobe is flagged implied and tagged with the current partition, and that the assignment state does not change during a conflict with no other command. The bench scenarios are needed for what depends on clause contents. These are the exact values and levels produced by implication chains, the number of cycles `busy_o` stays high for a chain of a given length, the choice of the lowest conflicting slot, the skip answer, and a learned clause that first causes a conflict and later an implication.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10
  } lit_e;
endpackage

// File: rtl/clause_eval.sv
module clause_eval
  import sat_pkg::*;
#(
  parameter int NV = 16
) (
  input  logic            valid_i,
  input  logic [2*NV-1:0] row_i,
  input  logic [NV-1:0]   asg_i,
  input  logic [NV-1:0]   val_i,
  output logic            unsat_o,
  output logic            conf_o,
  output logic [NV-1:0]   occ_o,
  output logic [NV-1:0]   imp_req_o,
  output logic [NV-1:0]   imp_one_o
);
  logic [NV-1:0] pos_m, neg_m, tru_m, open_m;
  logic          any_tru, unit;

  always_comb begin
    for (int v = 0; v < NV; v++) begin
      pos_m[v]  = row_i[2*v +: 2] == LIT_POS;
      neg_m[v]  = row_i[2*v +: 2] == LIT_NEG;
      tru_m[v]  = asg_i[v] & ((pos_m[v] & val_i[v]) | (neg_m[v] & ~val_i[v]));
      open_m[v] = (pos_m[v] | neg_m[v]) & ~asg_i[v];
    end
  end

  assign any_tru   = |tru_m;
  assign occ_o     = pos_m | neg_m;
  assign unsat_o   = valid_i & ~any_tru;
  assign unit      = unsat_o & ($countones(open_m) == 1);
  assign conf_o    = unsat_o & (open_m == '0);
  assign imp_req_o = unit ? open_m : '0;
  assign imp_one_o = unit ? (open_m & pos_m) : '0;
endmodule

// File: rtl/conf_pick.sv
module conf_pick #(
  parameter int NS = 32,
  parameter int NV = 16
) (
  input  logic [NS-1:0]    conf_i,
  input  logic [NS*NV-1:0] occ_i,
  output logic             any_o,
  output logic [NV-1:0]    vars_o
);
  // lowest slot wins: scan downward so the last write is the smallest index
  always_comb begin
    vars_o = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (conf_i[s]) vars_o = occ_i[s*NV +: NV];
    end
  end

  assign any_o = |conf_i;
endmodule

// File: rtl/var_state.sv
module var_state #(
  parameter int NV    = 16,
  parameter int LVL_W = 8,
  parameter int BIN_W = 8,
  parameter int VAR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bt_en_i,
  input  logic [LVL_W-1:0] bt_lvl_i,
  input  logic             asg_en_i,
  input  logic [VAR_W-1:0] asg_var_i,
  input  logic             asg_val_i,
  input  logic [LVL_W-1:0] asg_lvl_i,
  input  logic             imp_en_i,
  input  logic [NV-1:0]    imp_req_i,
  input  logic [NV-1:0]    imp_one_i,
  input  logic [LVL_W-1:0] imp_lvl_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic [NV-1:0]    asg_o,
  output logic [NV-1:0]    val_o,
  output logic [NV-1:0]    imp_o,
  output logic [NV*LVL_W-1:0] lvl_o,
  output logic [NV*BIN_W-1:0] bin_o
);
  for (genvar v = 0; v < NV; v++) begin : g_var
    logic             asg_q, val_q, imp_q;
    logic [LVL_W-1:0] lvl_q;
    logic [BIN_W-1:0] bin_q;
    logic             hit;

    assign hit = asg_en_i && (asg_var_i == VAR_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        asg_q <= 1'b0;
        val_q <= 1'b0;
        imp_q <= 1'b0;
        lvl_q <= '0;
        bin_q <= '0;
      end else if (clr_i) begin
        asg_q <= 1'b0;
        imp_q <= 1'b0;
      end else if (bt_en_i) begin
        if (lvl_q > bt_lvl_i) begin
          asg_q <= 1'b0;
          imp_q <= 1'b0;
        end
      end else if (hit) begin
        asg_q <= 1'b1;
        val_q <= asg_val_i;
        imp_q <= 1'b0;
        lvl_q <= asg_lvl_i;
        bin_q <= bin_i;
      end else if (imp_en_i && imp_req_i[v]) begin
        asg_q <= 1'b1;
        val_q <= imp_one_i[v];
        imp_q <= 1'b1;
        lvl_q <= imp_lvl_i;
        bin_q <= bin_i;
      end
    end

    assign asg_o[v] = asg_q;
    assign val_o[v] = val_q;
    assign imp_o[v] = imp_q;
    assign lvl_o[v*LVL_W +: LVL_W] = lvl_q;
    assign bin_o[v*BIN_W +: BIN_W] = bin_q;
  end
endmodule

// File: rtl/bin_implication_array.sv
module bin_implication_array
  import sat_pkg::*;
#(
  parameter int NUM_VARS    = 16,
  parameter int NUM_CLAUSES = 24,
  parameter int NUM_LEARN   = 8,
  parameter int LVL_W       = 8,
  parameter int BIN_W       = 8,
  localparam int NS         = NUM_CLAUSES + NUM_LEARN,
  localparam int SLOT_W     = (NS > 1) ? $clog2(NS) : 1,
  localparam int VAR_W      = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
  localparam int ROW_W      = 2 * NUM_VARS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SLOT_W-1:0]         wr_slot_i,
  input  logic [ROW_W-1:0]          wr_row_i,
  input  logic                      wr_valid_i,
  input  logic                      clr_i,
  input  logic                      bt_en_i,
  input  logic [LVL_W-1:0]          bt_lvl_i,
  input  logic                      asg_en_i,
  input  logic [VAR_W-1:0]          asg_var_i,
  input  logic                      asg_val_i,
  input  logic [LVL_W-1:0]          asg_lvl_i,
  input  logic [BIN_W-1:0]          cur_bin_i,
  input  logic [VAR_W-1:0]          qry_var_i,
  output logic [NUM_VARS-1:0]       var_asg_o,
  output logic [NUM_VARS-1:0]       var_val_o,
  output logic [NUM_VARS-1:0]       var_imp_o,
  output logic [NUM_VARS*LVL_W-1:0] var_lvl_o,
  output logic [NUM_VARS*BIN_W-1:0] var_bin_o,
  output logic                      busy_o,
  output logic                      sat_o,
  output logic                      conflict_o,
  output logic [NUM_VARS-1:0]       conf_vars_o,
  output logic                      skip_o
);
  logic [NS-1:0]          unsat_v, conf_v;
  logic [NS*NUM_VARS-1:0] occ_f, req_f, one_f;
  logic [NUM_VARS-1:0]    imp_req, imp_one;
  logic                   conf_any, imp_any, imp_en, busy_q;
  logic [LVL_W-1:0]       prop_lvl_q;

  // clause slots: original ones first, learned ones above them
  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic [ROW_W-1:0] row_q;
    logic             vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
        vld_q <= 1'b0;
      end else if (wr_en_i && (wr_slot_i == SLOT_W'(s))) begin
        row_q <= wr_row_i;
        vld_q <= wr_valid_i;
      end
    end

    clause_eval #(.NV(NUM_VARS)) i_clause (
      .valid_i  (vld_q),
      .row_i    (row_q),
      .asg_i    (var_asg_o),
      .val_i    (var_val_o),
      .unsat_o  (unsat_v[s]),
      .conf_o   (conf_v[s]),
      .occ_o    (occ_f[s*NUM_VARS +: NUM_VARS]),
      .imp_req_o(req_f[s*NUM_VARS +: NUM_VARS]),
      .imp_one_o(one_f[s*NUM_VARS +: NUM_VARS])
    );
  end

  // merge implications; a 1 wins over a 0, the loser becomes a conflict next cycle
  always_comb begin
    imp_req = '0;
    imp_one = '0;
    for (int s = 0; s < NS; s++) begin
      imp_req |= req_f[s*NUM_VARS +: NUM_VARS];
      imp_one |= one_f[s*NUM_VARS +: NUM_VARS];
    end
  end

  conf_pick #(.NS(NS), .NV(NUM_VARS)) i_conf_pick (
    .conf_i(conf_v),
    .occ_i (occ_f),
    .any_o (conf_any),
    .vars_o(conf_vars_o)
  );

  assign imp_any = |imp_req;
  assign imp_en  = ~conf_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prop_lvl_q <= '0;
      busy_q     <= 1'b0;
    end else begin
      if (bt_en_i)       prop_lvl_q <= bt_lvl_i;
      else if (asg_en_i) prop_lvl_q <= asg_lvl_i;
      busy_q <= ~clr_i & (bt_en_i | asg_en_i | wr_en_i | (imp_any & imp_en));
    end
  end

  var_state #(
    .NV(NUM_VARS), .LVL_W(LVL_W), .BIN_W(BIN_W), .VAR_W(VAR_W)
  ) i_var_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .bt_en_i  (bt_en_i),
    .bt_lvl_i (bt_lvl_i),
    .asg_en_i (asg_en_i),
    .asg_var_i(asg_var_i),
    .asg_val_i(asg_val_i),
    .asg_lvl_i(asg_lvl_i),
    .imp_en_i (imp_en),
    .imp_req_i(imp_req),
    .imp_one_i(imp_one),
    .imp_lvl_i(prop_lvl_q),
    .bin_i    (cur_bin_i),
    .asg_o    (var_asg_o),
    .val_o    (var_val_o),
    .imp_o    (var_imp_o),
    .lvl_o    (var_lvl_o),
    .bin_o    (var_bin_o)
  );

  always_comb begin
    skip_o = 1'b1;
    for (int s = 0; s < NS; s++) begin
      if (unsat_v[s] && occ_f[s*NUM_VARS + int'(qry_var_i)]) skip_o = 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign conflict_o = conf_any;
  assign sat_o      = ~conf_any & (unsat_v == '0);
endmodule

// File: rtl/bin_implication_array_chk.sv
module bin_implication_array_chk #(
  parameter int NUM_VARS = 16,
  parameter int LVL_W    = 8,
  parameter int BIN_W    = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic                      clr_i,
  input logic                      bt_en_i,
  input logic [LVL_W-1:0]          bt_lvl_i,
  input logic                      asg_en_i,
  input logic [BIN_W-1:0]          cur_bin_i,
  input logic [NUM_VARS-1:0]       var_asg_o,
  input logic [NUM_VARS-1:0]       var_imp_o,
  input logic [NUM_VARS*LVL_W-1:0] var_lvl_o,
  input logic [NUM_VARS*BIN_W-1:0] var_bin_o,
  input logic                      busy_o,
  input logic                      sat_o,
  input logic                      conflict_o,
  input logic [NUM_VARS-1:0]       conf_vars_o
);
  AST_SAT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> !conflict_o); // R7

  AST_CONF_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conflict_o |-> conf_vars_o == '0); // R6

  AST_CONF_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !clr_i && !bt_en_i && !asg_en_i && !wr_en_i) |=> $stable(var_asg_o)); // R6

  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asg_en_i && !clr_i) |=> busy_o); // R5

  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> var_asg_o == '0); // R10

  for (genvar v = 0; v < NUM_VARS; v++) begin : g_v
    AST_BT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bt_en_i && var_lvl_o[v*LVL_W +: LVL_W] > bt_lvl_i) |=> !var_asg_o[v]); // R9

    AST_IMP_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(var_asg_o[v]) && !$past(asg_en_i)) |->
        (var_imp_o[v] && var_bin_o[v*BIN_W +: BIN_W] == $past(cur_bin_i))); // R4
  end
endmodule

bind bin_implication_array bin_implication_array_chk #(
  .NUM_VARS(NUM_VARS), .LVL_W(LVL_W), .BIN_W(BIN_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .clr_i      (clr_i),
  .bt_en_i    (bt_en_i),
  .bt_lvl_i   (bt_lvl_i),
  .asg_en_i   (asg_en_i),
  .cur_bin_i  (cur_bin_i),
  .var_asg_o  (var_asg_o),
  .var_imp_o  (var_imp_o),
  .var_lvl_o  (var_lvl_o),
  .var_bin_o  (var_bin_o),
  .busy_o     (busy_o),
  .sat_o      (sat_o),
  .conflict_o (conflict_o),
  .conf_vars_o(conf_vars_o)
);

// File: tb/test_bin_implication_array.sv
module test_bin_implication_array;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int NC = 24;
  localparam int NL = 8;

  typedef struct packed {
    logic [3:0]  var_id;
    logic        val;
    logic [7:0]  lvl;
    logic [15:0] e_asg;
    logic [15:0] e_val;
    logic        e_sat;
    logic [3:0]  e_busy;
  } step_t;

  // clauses: c0 (x0|x1) c1 (!x1|x2) c2 (!x2|x3|x4) c3 (!x0|!x3) c4 (x5|x6)
  localparam step_t STEPS [3] = '{
    '{4'd0, 1'b0, 8'd1, 16'h0007, 16'h0006, 1'b0, 4'd3},
    '{4'd4, 1'b0, 8'd2, 16'h001F, 16'h000E, 1'b0, 4'd2},
    '{4'd5, 1'b1, 8'd3, 16'h003F, 16'h002E, 1'b1, 4'd1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0, wr_valid = 0, clr = 0, bt_en = 0, asg_en = 0, asg_val = 0;
  logic [4:0]  wr_slot = '0;
  logic [31:0] wr_row = '0;
  logic [7:0]  bt_lvl = '0, asg_lvl = '0, cur_bin = 8'd5;
  logic [3:0]  asg_var = '0, qry_var = '0;
  logic [NV-1:0] var_asg, var_val, var_imp, conf_vars;
  logic [NV*8-1:0] var_lvl, var_bin;
  logic busy, sat, conflict, skip;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_implication_array #(.NUM_VARS(NV), .NUM_CLAUSES(NC), .NUM_LEARN(NL)) i_bin_implication_array (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_row_i(wr_row),
    .wr_valid_i(wr_valid), .clr_i(clr), .bt_en_i(bt_en), .bt_lvl_i(bt_lvl), .asg_en_i(asg_en),
    .asg_var_i(asg_var), .asg_val_i(asg_val), .asg_lvl_i(asg_lvl), .cur_bin_i(cur_bin),
    .qry_var_i(qry_var), .var_asg_o(var_asg), .var_val_o(var_val), .var_imp_o(var_imp),
    .var_lvl_o(var_lvl), .var_bin_o(var_bin), .busy_o(busy), .sat_o(sat),
    .conflict_o(conflict), .conf_vars_o(conf_vars), .skip_o(skip)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lit(input int v, input bit pos);
    lit = '0;
    lit[2*v +: 2] = pos ? 2'b01 : 2'b10;
  endfunction

  task automatic write_slot(input int s, input logic [31:0] row, input logic vld);
    @(negedge clk);
    wr_en = 1; wr_slot = 5'(s); wr_row = row; wr_valid = vld;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic settle(output int n);
    n = 0;
    while (busy && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic assign_var(input logic [3:0] v, input logic val, input logic [7:0] l, output int n);
    @(negedge clk);
    asg_en = 1; asg_var = v; asg_val = val; asg_lvl = l;
    @(negedge clk);
    asg_en = 0;
    settle(n);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // reset state
    check("R10 reset asg", 64'(var_asg), 0);
    check("R5 reset busy", 64'(busy), 0);
    check("R7 empty sat", 64'(sat), 1);
    check("R6 reset conflict", 64'(conflict), 0);

    write_slot(0, lit(0,1) | lit(1,1), 1);
    write_slot(1, lit(1,0) | lit(2,1), 1);
    write_slot(2, lit(2,0) | lit(3,1) | lit(4,1), 1);
    write_slot(3, lit(0,0) | lit(3,0), 1);
    write_slot(4, lit(5,1) | lit(6,1), 1);
    write_slot(7, lit(9,1), 0);   // R1 invalid slot ignored
    settle(n);
    check("R1 invalid slot no conflict", 64'(conflict), 0);
    check("R7 unsat after load", 64'(sat), 0);
    qry_var = 4'd6; #1;
    check("R8 skip open var", 64'(skip), 0);
    qry_var = 4'd9; #1;
    check("R8 skip absent var", 64'(skip), 1);

    for (int i = 0; i < 3; i++) begin
      assign_var(STEPS[i].var_id, STEPS[i].val, STEPS[i].lvl, n);
      check("R3 asg mask", 64'(var_asg), 64'(STEPS[i].e_asg));
      check("R3 values", 64'(var_val), 64'(STEPS[i].e_val));
      check("R5 busy cycles", 64'(n), 64'(STEPS[i].e_busy));
      check("R7 sat", 64'(sat), 64'(STEPS[i].e_sat));
    end

    check("R2 x0 lvl", 64'(var_lvl[0 +: 8]), 1);
    check("R2 x0 not implied", 64'(var_imp[0]), 0);
    check("R2 x0 bin", 64'(var_bin[0 +: 8]), 5);
    check("R4 x1 lvl", 64'(var_lvl[8 +: 8]), 1);
    check("R4 x3 lvl", 64'(var_lvl[24 +: 8]), 2);
    check("R4 x3 bin", 64'(var_bin[24 +: 8]), 5);
    check("R3 implied flags", 64'(var_imp), 64'h000E);
    qry_var = 4'd6; #1;
    check("R8 skip satisfied var", 64'(skip), 1);

    // backtrack to level 1
    @(negedge clk);
    bt_en = 1; bt_lvl = 8'd1;
    @(negedge clk);
    bt_en = 0;
    settle(n);
    check("R9 backtrack asg", 64'(var_asg), 64'h0007);

    // learned clause (!x1|!x2) is false at once
    write_slot(NC, lit(1,0) | lit(2,0), 1);
    check("R11 learned conflict", 64'(conflict), 1);
    check("R6 conflict vars", 64'(conf_vars), 64'h0006);
    check("R7 no sat on conflict", 64'(sat), 0);
    write_slot(1, lit(1,0) | lit(2,1), 1);
    write_slot(2, lit(0,1) | lit(1,0), 1);  // also false, lower slot
    check("R6 lowest slot", 64'(conf_vars), 64'h0003);
    write_slot(2, lit(2,0) | lit(3,1) | lit(4,1), 1);
    write_slot(NC, '0, 0);
    check("R1 invalidated slot", 64'(conflict), 0);

    // learned clause (!x2|x7) implies x7
    write_slot(NC + 1, lit(2,0) | lit(7,1), 1);
    settle(n);
    check("R11 learned implication", 64'(var_asg[7] & var_val[7]), 1);
    check("R4 learned lvl", 64'(var_lvl[56 +: 8]), 1);

    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    check("R10 clear asg", 64'(var_asg), 0);
    check("R10 clauses kept", 64'(sat), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule